// File: doc/BRIEF.md
# Five-State Custom-Sequence Counter with Selectable Flip-Flop Style

This block is a 3-bit synchronous counter. It does not count in binary. It follows a fixed loop of five codes: 000, 010, 011, 101 and 110, and after 110 it goes back to 000. The three bits are named C (bit 2, most significant), B (bit 1) and A (bit 0). The codes 001, 100 and 111 are not part of the loop. The design may treat their successors as don't-cares.

A parameter selects how the state is stored. There are four choices: toggle (T), set/reset (R-S), J-K, or plain data (D) storage elements. Each choice has its own behavioural flip-flop model and its own minimized excitation equations. All four produce the same sequence of codes.

The counter advances on a rising clock edge only while the count enable is high. When the enable is low, the excitation for every style is forced to "hold". An active-low reset clears the counter to 000 at once, without waiting for a clock edge.

Top module: `custom_seq_counter`

## Requirements
- R1: While `rstN` is low, `state` is 000, and it becomes 000 as soon as `rstN` falls, without waiting for a clock edge.
- R2: On a rising clock edge with `countEn` high, `state` moves to its successor in the loop: 000 goes to 010, 010 goes to 011, 011 goes to 101, and 101 goes to 110.
- R3: On a rising clock edge with `countEn` low, `state` keeps its value.
- R4: After reset, `state` never takes the unused codes 001, 100 or 111.
- R5: In the R-S style, no bit ever has its set and reset inputs high at the same time.
- R6: The T, R-S, J-K and D styles produce the same `state` on every cycle when they receive the same reset and enable stimulus. The style is selected by `STYLE`: 0 = T, 1 = R-S, 2 = J-K, 3 = D.
- R7: On a rising clock edge with `countEn` high and `state` at 110, `state` wraps to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset; clears the counter to 000 |
| countEn | input | 1 | High lets the counter advance on the next edge; low holds it |
| state | output | 3 | Current code, bit 2 = C, bit 1 = B, bit 0 = A |

## Verification
The bench runs all four styles side by side from one reset and one enable signal. It compares each of them with a lookup of the five-state loop. A fixed table of enable values covers several cases:
- long runs of high enable, which step through the loop and wrap from 110 back to 000;
- single and double low cycles placed in different states, which show that a hold differs from a step;
- a low enable at the wrap point.

A pseudo-random enable phase then gives each style many different hold and step sequences. A wrong excitation term in one style makes that style drift away from the other three and from the lookup. Directed tests drop the reset between clock edges, in the middle of the loop, and check that the state clears at once. They also hold reset with the enable high and check that the counter does not move.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    STYLE_T  = 2'd0,
    STYLE_RS = 2'd1,
    STYLE_JK = 2'd2,
    STYLE_D  = 2'd3
  } ffStyle_e;

  // Strobes handed from the excitation logic to the storage cells.
  // exA: T, S, J or D input; exB: R or K input (unused for T and D).
  typedef struct packed {
    logic [CNT_W-1:0] exA;
    logic [CNT_W-1:0] exB;
  } ctrlStrobe_t;

  // Successor lookup of the loop, written as a plain table.
  function automatic logic [CNT_W-1:0] nextCode(input logic [CNT_W-1:0] cur);
    case (cur)
      3'b000:  nextCode = 3'b010;
      3'b010:  nextCode = 3'b011;
      3'b011:  nextCode = 3'b101;
      3'b101:  nextCode = 3'b110;
      3'b110:  nextCode = 3'b000;
      default: nextCode = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/seqcnt_ctrl.sv
module seqcnt_ctrl
  import seqcnt_pkg::*;
#(
  parameter ffStyle_e STYLE = STYLE_D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic [CNT_W-1:0] state,
  output ctrlStrobe_t      strobe
);

  logic bitC, bitB, bitA;
  assign bitC = state[2];
  assign bitB = state[1];
  assign bitA = state[0];

  generate
    if (STYLE == STYLE_T) begin : g_t
      always_comb begin
        strobe.exB = '0;
        if (countEn) begin
          strobe.exA[2] = bitA ^ bitC;
          strobe.exA[1] = bitA | ~bitB | bitC;
          strobe.exA[0] = (bitA & ~bitB & bitC) | (~bitA & bitB & ~bitC);
        end else begin
          strobe.exA = '0;
        end
      end
    end else if (STYLE == STYLE_RS) begin : g_rs
      always_comb begin
        if (countEn) begin
          strobe.exA[2] = bitA;
          strobe.exB[2] = ~bitA;
          strobe.exA[1] = ~bitB;
          strobe.exB[1] = bitB & (bitA | bitC);
          strobe.exA[0] = bitB & ~bitC;
          strobe.exB[0] = bitC;
        end else begin
          strobe.exA = '0;
          strobe.exB = '0;
        end
      end

      assert_rs_exclusive_R5: assert property (
        @(posedge clk) disable iff (!rstN)
        (strobe.exA & strobe.exB) == '0
      ) else $error("set and reset both high");
    end else if (STYLE == STYLE_JK) begin : g_jk
      always_comb begin
        if (countEn) begin
          strobe.exA[2] = bitA;
          strobe.exB[2] = ~bitA;
          strobe.exA[1] = 1'b1;
          strobe.exB[1] = bitA | bitC;
          strobe.exA[0] = bitB & ~bitC;
          strobe.exB[0] = bitC;
        end else begin
          strobe.exA = '0;
          strobe.exB = '0;
        end
      end
    end else begin : g_d
      always_comb begin
        strobe.exB = '0;
        if (countEn) begin
          strobe.exA[2] = bitA;
          strobe.exA[1] = (~bitA & ~bitC) | ~bitB;
          strobe.exA[0] = bitB & ~bitC;
        end else begin
          strobe.exA = state;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/seqcnt_ffcell.sv
module seqcnt_ffcell
  import seqcnt_pkg::*;
#(
  parameter ffStyle_e STYLE = STYLE_D
) (
  input  logic clk,
  input  logic rstN,
  input  logic inA,
  input  logic inB,
  output logic q
);

  generate
    if (STYLE == STYLE_T) begin : g_t
      logic unusedInB;
      assign unusedInB = inB;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    q <= 1'b0;
        else if (inA) q <= ~q;
      end
    end else if (STYLE == STYLE_RS) begin : g_rs
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    q <= 1'b0;
        else if (inA) q <= 1'b1;
        else if (inB) q <= 1'b0;
      end
    end else if (STYLE == STYLE_JK) begin : g_jk
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else begin
          case ({inA, inB})
            2'b10:   q <= 1'b1;
            2'b01:   q <= 1'b0;
            2'b11:   q <= ~q;
            default: q <= q;
          endcase
        end
      end
    end else begin : g_d
      logic unusedInB;
      assign unusedInB = inB;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= inA;
      end
    end
  endgenerate

endmodule

// File: rtl/seqcnt_datapath.sv
module seqcnt_datapath
  import seqcnt_pkg::*;
#(
  parameter ffStyle_e STYLE = STYLE_D
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] state
);

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    seqcnt_ffcell #(.STYLE(STYLE)) u_cell (
      .clk  (clk),
      .rstN (rstN),
      .inA  (strobe.exA[i]),
      .inB  (strobe.exB[i]),
      .q    (state[i])
    );
  end

endmodule

// File: rtl/custom_seq_counter.sv
module custom_seq_counter
  import seqcnt_pkg::*;
#(
  parameter ffStyle_e STYLE = STYLE_D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  output logic [CNT_W-1:0] state
);

  ctrlStrobe_t strobe;

  seqcnt_ctrl #(.STYLE(STYLE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .countEn (countEn),
    .state   (state),
    .strobe  (strobe)
  );

  seqcnt_datapath #(.STYLE(STYLE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .state  (state)
  );

  assert_step_R2: assert property (
    @(posedge clk) disable iff (!rstN)
    countEn |=> state == nextCode($past(state))
  ) else $error("wrong successor");

  assert_hold_R3: assert property (
    @(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(state)
  ) else $error("state moved while disabled");

  assert_legal_code_R4: assert property (
    @(posedge clk) disable iff (!rstN)
    state != 3'b001 && state != 3'b100 && state != 3'b111
  ) else $error("unused code reached");

  assert_wrap_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    (countEn && state == 3'b110) |=> state == 3'b000
  ) else $error("no wrap from 110");

endmodule

// File: tb/custom_seq_counter_tb.sv
module custom_seq_counter_tb;
  import seqcnt_pkg::*;

  localparam int NSTY = 4;
  localparam int NVEC = 16;

  typedef struct packed {
    logic       en;
    logic [2:0] exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'b010}, '{1'b1, 3'b011}, '{1'b0, 3'b011}, '{1'b1, 3'b101},
    '{1'b0, 3'b101}, '{1'b0, 3'b101}, '{1'b1, 3'b110}, '{1'b1, 3'b000},
    '{1'b1, 3'b010}, '{1'b0, 3'b010}, '{1'b1, 3'b011}, '{1'b1, 3'b101},
    '{1'b1, 3'b110}, '{1'b0, 3'b110}, '{1'b1, 3'b000}, '{1'b0, 3'b000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 1'b0;
  logic [2:0] obs [NSTY];
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < NSTY; g++) begin : g_sty
    custom_seq_counter #(.STYLE(ffStyle_e'(g))) u_dut (
      .clk     (clk),
      .rstN    (rstN),
      .countEn (countEn),
      .state   (obs[g])
    );
  end

  task automatic checkAll(input logic [2:0] exp, input string req);
    for (int s = 0; s < NSTY; s++) begin
      checks++;
      if (obs[s] !== exp) begin
        fails++;
        $display("FAIL %s style %0d: actual %b expected %b", req, s, obs[s], exp);
      end
    end
  endtask

  function automatic logic [2:0] refNext(input logic [2:0] cur);
    case (cur)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  task automatic stepCheck(input logic en, input logic [2:0] exp, input string req);
    @(negedge clk);
    countEn = en;
    @(posedge clk);
    #2;
    checkAll(exp, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] model;
    logic en;
    // R1: counter cleared during reset, even with enable high across edges
    countEn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checkAll(3'b000, "R1 reset hold");
    @(negedge clk);
    countEn = 1'b0;
    rstN = 1'b1;

    // Vector table: R2 steps, R3 holds, R7 wrap, R6 styles agree
    for (int v = 0; v < NVEC; v++) begin
      stepCheck(VECS[v].en, VECS[v].exp, "R2/R3/R7 table, R6");
    end

    // Pseudo-random enable against the lookup (R6, R4 via agreement)
    model = 3'b000;
    for (int k = 0; k < 300; k++) begin
      en = 1'($urandom_range(0, 1));
      if (en) model = refNext(model);
      stepCheck(en, model, "R6 random");
    end

    // R1: asynchronous clear in mid-loop, between edges
    while (model != 3'b011) begin
      model = refNext(model);
      stepCheck(1'b1, model, "R2 advance to 011");
    end
    @(negedge clk);
    countEn = 1'b0;
    #1;
    rstN = 1'b0;
    #1;
    checkAll(3'b000, "R1 async clear");
    @(posedge clk);
    #2;
    checkAll(3'b000, "R1 stays clear");
    @(negedge clk);
    rstN = 1'b1;
    stepCheck(1'b1, 3'b010, "R2 restart after reset");
    stepCheck(1'b0, 3'b010, "R3 hold at 010");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule